// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block is a small data cache placed between a processor load/store port and a memory port that moves one whole line per transfer. Each request address is cut into a block offset (low bits), a set index (middle bits) and a tag (the remaining high bits). Every way of the indexed set is compared against the tag. A hit returns a zero-extended byte, halfword or word, or merges write data into the cached line and marks it modified. Memory is not touched on a hit.

On a miss the controller picks a way. An empty way comes first. If every way holds data, it takes the way just after the most recently touched one. A modified victim is first copied out to memory, then the wanted line is fetched. The access is then replayed as a hit, so a write miss merges its bytes into the freshly fetched line. The processor side is held off for the whole sequence. The default geometry is a 16-bit address, 16-byte lines, 8 lines and 2 ways, which gives 4 sets.

Top module: `cache_wb_ctrl`

## Requirements
- R1: The offset is the low log2(LINE_BYTES) address bits, the set index is the next log2(NUM_LINES/WAYS) bits, and the tag is the rest. By default the index is addr[5:4], so 0x1833 belongs to set 3. Every memory transfer addresses a whole line, with its offset bits zero; a fetch uses the requesting address with the offset cleared.
- R2: After reset every line is empty and clean, req_ready is 1, and rsp_valid and mem_req are 0. The first access to any line therefore fetches it from memory.
- R3: A hit makes no memory request. rsp_valid rises two clock edges after the edge that accepted the request.
- R4: req_size encodes the width: 0 = byte, 1 = halfword, 2 = word. A read returns the bytes starting at the line offset, lowest address in bits [7:0], with zeros above the requested width.
- R5: A write hit changes only the cached line and marks it dirty. No memory write occurs, and a later read returns the merged bytes.
- R6: A write miss fetches the line, merges the written bytes into it, and leaves it dirty.
- R7: On a miss, the lowest-numbered empty way of the set is filled and nothing is written back.
- R8: When every way of the set is valid, the victim is the way numbered one above the set's most-recently-used way, wrapping around. The most-recently-used way is updated on every hit and every fill.
- R9: A dirty victim is written to memory, at its own line address and with its current contents, before the new line is fetched. A clean victim is overwritten without any memory write.
- R10: mem_req stays high with unchanged mem_addr, mem_we and mem_wdata until mem_ack is seen. The memory may take any number of cycles.
- R11: req_ready is low from the accepting edge until the response cycle has passed.
- R12: rsp_valid is a single-cycle pulse, given once per accepted access (reads and writes alike).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (0 byte, 1 half, 2 word) |
| req_wdata | input | 32 | Store data, lowest byte goes to the lowest address |
| rsp_valid | output | 1 | Access complete (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data, zero-extended |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write-back of a line, 0 = line fetch |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line being written back |
| mem_ack | input | 1 | Transfer done (fetch data valid in this cycle) |
| mem_rdata | input | LINE_BYTES*8 | Fetched line |

## Verification
A hit answers with rsp_valid exactly two edges after the accepting edge. A miss adds one or two memory transfers, each lasting as long as the memory model chooses to delay mem_ack. The bench drives and samples only on falling edges. It counts falling edges from acceptance until rsp_valid, and expects exactly two when its own tag model predicts a hit. It also records every memory transfer at the falling edge where mem_ack is raised. After each response it compares the count, kind, address and data of those transfers against the write-back and fetch its model expects, and checks one edge later that the pulse has dropped and req_ready has returned.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOOKUP  = 3'd1,
        ST_WRBACK  = 3'd2,
        ST_REFILL  = 3'd3,
        ST_RESPOND = 3'd4
    } ctrl_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // number of bytes touched by an access of the given width code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);
    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 10,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid[w] && (set_tags[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  set_valid,
    input  logic [WAY_W-1:0] set_mru,
    output logic [WAY_W-1:0] victim
);
    if (WAYS == 1) begin : g_direct
        assign victim = '0;
    end else begin : g_assoc
        logic [WAY_W-1:0] after_mru;
        logic             found;

        assign after_mru = (set_mru == WAY_W'(WAYS - 1)) ? '0 : set_mru + 1'b1;

        always_comb begin
            victim = after_mru;
            found  = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (!set_valid[w] && !found) begin
                    victim = WAY_W'(w);
                    found  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cache_line_merge.sv
module cache_line_merge
    import cache_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [LINE_W-1:0] merged,
    output logic [31:0]       rdata
);
    logic [2:0]       nbytes;
    logic [OFF_W-1:0] pos;

    assign nbytes = size_bytes(size);

    always_comb begin
        merged = line;
        rdata  = '0;
        pos    = '0;
        for (int b = 0; b < 4; b++) begin
            pos = off + OFF_W'(b);
            if (3'(b) < nbytes) begin
                merged[pos*8 +: 8] = wdata[b*8 +: 8];
                rdata[b*8 +: 8]    = line[pos*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 8,
    parameter int WAYS       = 2,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SETS  = NUM_LINES / WAYS;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        ctrl_state_e                                st;
        logic [ADDR_W-1:0]                          addr;
        logic                                       we;
        logic [1:0]                                 size;
        logic [31:0]                                wdata;
        logic [WAY_W-1:0]                           way;
        logic [31:0]                                rdata;
        logic [SETS-1:0][WAYS-1:0]                  valid;
        logic [SETS-1:0][WAYS-1:0]                  dirty;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]       tags;
        logic [SETS-1:0][WAYS-1:0][LINE_W-1:0]      lines;
        logic [SETS-1:0][WAY_W-1:0]                 mru;
    } regs_t;

    regs_t r_q, r_d;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic [LINE_W-1:0] merged;
    logic [31:0]       rd_bytes;

    cache_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_split (
        .addr(r_q.addr), .tag(a_tag), .idx(a_idx), .off(a_off)
    );

    cache_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_match (
        .set_valid(r_q.valid[a_idx]),
        .set_tags (r_q.tags[a_idx]),
        .tag      (a_tag),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    cache_victim_pick #(
        .WAYS(WAYS)
    ) u_victim (
        .set_valid(r_q.valid[a_idx]),
        .set_mru  (r_q.mru[a_idx]),
        .victim   (victim)
    );

    cache_line_merge #(
        .LINE_BYTES(LINE_BYTES)
    ) u_merge (
        .line  (r_q.lines[a_idx][hit_way]),
        .off   (a_off),
        .size  (r_q.size),
        .wdata (r_q.wdata),
        .merged(merged),
        .rdata (rd_bytes)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.we    = req_we;
                    r_d.size  = req_size;
                    r_d.wdata = req_wdata;
                    r_d.st    = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    r_d.mru[a_idx] = hit_way;
                    if (r_q.we) begin
                        r_d.lines[a_idx][hit_way] = merged;
                        r_d.dirty[a_idx][hit_way] = 1'b1;
                        r_d.rdata                 = '0;
                    end else begin
                        r_d.rdata = rd_bytes;
                    end
                    r_d.st = ST_RESPOND;
                end else begin
                    r_d.way = victim;
                    if (r_q.valid[a_idx][victim] && r_q.dirty[a_idx][victim]) begin
                        r_d.st = ST_WRBACK;
                    end else begin
                        r_d.st = ST_REFILL;
                    end
                end
            end
            ST_WRBACK: begin
                if (mem_ack) begin
                    r_d.dirty[a_idx][r_q.way] = 1'b0;
                    r_d.st                    = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (mem_ack) begin
                    r_d.lines[a_idx][r_q.way] = mem_rdata;
                    r_d.tags[a_idx][r_q.way]  = a_tag;
                    r_d.valid[a_idx][r_q.way] = 1'b1;
                    r_d.dirty[a_idx][r_q.way] = 1'b0;
                    r_d.mru[a_idx]            = r_q.way;
                    r_d.st                    = ST_LOOKUP;
                end
            end
            ST_RESPOND: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = (r_q.st == ST_RESPOND);
    assign rsp_rdata = r_q.rdata;
    assign mem_req   = (r_q.st == ST_WRBACK) || (r_q.st == ST_REFILL);
    assign mem_we    = (r_q.st == ST_WRBACK);
    assign mem_addr  = (r_q.st == ST_WRBACK)
                     ? {r_q.tags[a_idx][r_q.way], a_idx, {OFF_W{1'b0}}}
                     : {a_tag, a_idx, {OFF_W{1'b0}}};
    assign mem_wdata = r_q.lines[a_idx][r_q.way];

endmodule

// File: rtl/cache_wb_chk.sv
module cache_wb_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R1
    mem_line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    stall_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    no_ready_in_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    // R3
    hit_resp_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req);
endmodule

bind cache_wb_ctrl cache_wb_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_W(LINE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack)
);

// File: tb/sim_cache_wb_ctrl.sv
module sim_cache_wb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int MEMB       = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_addr = '0;
    logic         req_we = 1'b0;
    logic [1:0]   req_size = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_wb_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] gm [MEMB];   // processor-visible contents
    logic [7:0] mm [MEMB];   // what memory actually holds

    int           n_mrd, n_mwr;
    logic [15:0]  last_rd_addr, last_wr_addr;
    logic [127:0] last_wr_data;

    // reference tag model: 4 sets x 2 ways
    logic       mv  [4][2];
    logic       md  [4][2];
    logic [9:0] mt  [4][2];
    int         mru [4];

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] gm_line(input logic [15:0] base);
        logic [127:0] v;
        for (int b = 0; b < 16; b++) v[b*8 +: 8] = gm[(int'(base) + b) % MEMB];
        return v;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // memory responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                logic [15:0] a0;
                a0 = mem_addr;
                repeat ($urandom_range(0, 4)) @(negedge clk);
                chk(mem_addr == a0, "R10 addr held", {112'd0, mem_addr}, {112'd0, a0});
                if (mem_we) begin
                    for (int b = 0; b < 16; b++) mm[(int'(mem_addr) + b) % MEMB] = mem_wdata[b*8 +: 8];
                    n_mwr++;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end else begin
                    for (int b = 0; b < 16; b++) mem_rdata[b*8 +: 8] = mm[(int'(mem_addr) + b) % MEMB];
                    n_mrd++;
                    last_rd_addr = mem_addr;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic access(input logic [15:0] a, input logic we, input logic [1:0] sz, input logic [31:0] wd);
        int          set, hitw, vic, cyc, nb;
        logic [9:0]  tg;
        logic        was_hit, exp_wb, rdy_bad;
        logic [15:0] wb_addr;
        logic [127:0] wb_data;
        logic [31:0] exp_rd;

        set = int'(a[5:4]);
        tg  = a[15:6];
        nb  = nbytes(sz);
        hitw = -1;
        for (int w = 0; w < 2; w++) if (mv[set][w] && mt[set][w] == tg) hitw = w;
        was_hit = (hitw >= 0);
        exp_wb  = 1'b0;
        wb_addr = '0;
        wb_data = '0;
        if (!was_hit) begin
            vic = -1;
            for (int w = 0; w < 2; w++) if (!mv[set][w] && vic < 0) vic = w;
            if (vic < 0) vic = (mru[set] + 1) % 2;
            if (mv[set][vic] && md[set][vic]) begin
                exp_wb  = 1'b1;
                wb_addr = {mt[set][vic], set[1:0], 4'h0};
                wb_data = gm_line(wb_addr);
            end
            mv[set][vic] = 1'b1;
            md[set][vic] = 1'b0;
            mt[set][vic] = tg;
            hitw = vic;
        end
        mru[set] = hitw;
        if (we) md[set][hitw] = 1'b1;
        exp_rd = '0;
        for (int b = 0; b < nb; b++) exp_rd[b*8 +: 8] = gm[(int'(a) + b) % MEMB];
        if (we) for (int b = 0; b < nb; b++) gm[(int'(a) + b) % MEMB] = wd[b*8 +: 8];

        n_mrd = 0;
        n_mwr = 0;
        rdy_bad = 1'b0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_we    = we;
        req_size  = sz;
        req_wdata = wd;
        @(posedge clk);
        cyc = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (req_ready) rdy_bad = 1'b1;
        end while (!rsp_valid && cyc < 2000);

        chk(!rdy_bad, "R11 stall", {127'd0, rdy_bad}, 128'd0);
        if (!we) chk(rsp_rdata == exp_rd, "R4 read data", {96'd0, rsp_rdata}, {96'd0, exp_rd});
        if (was_hit) begin
            chk(cyc == 2, "R3 hit latency", 128'(cyc), 128'd2);
            chk(n_mrd == 0 && n_mwr == 0, we ? "R5 write hit no memory" : "R3 hit no memory",
                128'(n_mrd + n_mwr), 128'd0);
        end else begin
            chk(n_mrd == 1, we ? "R6 write miss fetch" : "R2 miss fetch", 128'(n_mrd), 128'd1);
            chk(last_rd_addr == {a[15:4], 4'h0}, "R1 fetch address",
                {112'd0, last_rd_addr}, {112'd0, a[15:4], 4'h0});
            chk(n_mwr == (exp_wb ? 1 : 0), exp_wb ? "R9 dirty write-back" : "R7 no write-back",
                128'(n_mwr), exp_wb ? 128'd1 : 128'd0);
            if (exp_wb) begin
                chk(last_wr_addr == wb_addr, "R8 victim address", {112'd0, last_wr_addr}, {112'd0, wb_addr});
                chk(last_wr_data == wb_data, "R9 write-back data", last_wr_data, wb_data);
            end
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R12 single pulse", {126'd0, rsp_valid, req_ready}, 128'd1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < MEMB; i++) begin
            gm[i] = 8'((i * 37 + 11) ^ (i >> 3));
            mm[i] = gm[i];
        end
        for (int s = 0; s < 4; s++) begin
            mru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 1'b0;
                md[s][w] = 1'b0;
                mt[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R2 reset state",
            {125'd0, req_ready, rsp_valid, mem_req}, 128'd4);

        // directed: set 3 traffic
        access(16'h1833, 1'b0, 2'd0, 32'h0);           // R1 miss into set 3, way 0
        access(16'h1832, 1'b0, 2'd1, 32'h0);           // R3 R4 halfword hit
        access(16'h0074, 1'b1, 2'd2, 32'hCAFEF00D);    // R6 R7 write miss into empty way 1
        access(16'h0074, 1'b0, 2'd2, 32'h0);           // R5 read back merged word
        access(16'h1834, 1'b1, 2'd1, 32'h0000BEEF);    // R5 write hit, way 0 becomes MRU
        access(16'h00B0, 1'b0, 2'd0, 32'h0);           // R8 R9 victim is way 1 (0x0070)
        chk(last_wr_addr == 16'h0070, "R8 NMRU victim line", {112'd0, last_wr_addr}, 128'h0070);
        access(16'h0075, 1'b0, 2'd0, 32'h0);           // R9 evicts dirty 0x1830 line
        chk(last_wr_addr == 16'h1830, "R9 dirty victim line", {112'd0, last_wr_addr}, 128'h1830);
        access(16'h0076, 1'b0, 2'd1, 32'h0);           // R4 halfword of refetched data

        // random mix
        for (int i = 0; i < 2500; i++) begin
            logic [1:0]  sz;
            logic [15:0] a;
            sz = 2'($urandom_range(0, 2));
            a  = 16'($urandom_range(0, 511));
            a  = a & ~16'(nbytes(sz) - 1);
            access(a, 1'($urandom_range(0, 1)), sz, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule